// File: doc/BRIEF.md
# Reload Down-Counter Timer

A 16-bit timer that counts down on a selectable count-source strobe and returns to a programmed reload value each time it passes zero. Every pass through zero raises a one-cycle interrupt request, so a programmed value n gives one request every n+1 source ticks. The source is one of several internal division ratios of the system clock, or a divided-down external slow-clock enable.

Software loads a value through the timer write port, picks the source and the operating mode through a mode register, and starts or stops the count with a start bit. The live count is visible on a read port at all times. Whether a write reaches the live counter depends on the state of the current run. Before the first source tick of a run, or while stopped, a write sets both the counter and the reload register. After that first tick, a write changes only the reload value, and the counter takes it at the next underflow.

Top module: `rdt_timer`

## Requirements
- R1: After reset, `count_o` is 0, `mode_o` is 8'h00 and `irq_o` is 0.
- R2: While `start_i` is 1 and `mode_o[1:0]` is 2'b00, the count drops by exactly one on each selected source tick, and it does not change in any other cycle unless a write or a reload occurs.
- R3: A source tick at count 0 loads the reload value and drives `irq_o` high for the following cycle. A programmed value n, from 16'h0000 to 16'hFFFF, gives one request every n+1 ticks.
- R4: `mode_o[7:6]` selects the source. With 00, a tick occurs every clock when `half_rate_i` is 0, and on every second clock when it is 1. With 01, a tick occurs every 8th clock, and with 10 every 32nd clock. With 11, a tick occurs on every 32nd `slow_en_i` pulse. The internal divider phases count clocks from reset release, so a divide-by-k tick falls in the clocks where (clocks since reset) mod k equals k-1. The slow tick falls on the pulses where (pulses since reset) mod 32 equals 31.
- R5: While `start_i` is 0, the count holds its value and no request is raised.
- R6: A write while stopped, or after start but before the first source tick of the run, sets both the counter and the reload value. If such a write coincides with a tick, the written value wins and no decrement happens.
- R7: A write after the first source tick of a run changes only the reload value. The counter continues down and takes the new value at the next underflow.
- R8: When a write coincides with an underflow, the counter reloads with the value just written.
- R9: Counting happens only when `mode_o[1:0]` is 2'b00. Mode bits 5:4 always read 0, and all other mode bits read back as written.
- R10: Clearing `start_i` and setting it again begins a new run, so writes again reach the counter until that run's first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_wr_i | input | 1 | Timer register write strobe |
| tmr_wdata_i | input | 16 | Timer register write data |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode register write data |
| start_i | input | 1 | Start (1) / stop (0) control |
| half_rate_i | input | 1 | With source 00: 0 = every clock, 1 = every second clock |
| slow_en_i | input | 1 | External slow-clock enable pulse |
| count_o | output | 16 | Current counter value (read port) |
| mode_o | output | 8 | Mode register read-back |
| irq_o | output | 1 | One-cycle request per underflow |

## Verification
The hardest case to reach is a write landing between the start of a run and its first source tick. With fast sources, that window is only a few clocks wide and its position depends on the divider phase. The stimulus removes the race by selecting the slow source and holding `slow_en_i` low. The run then has no ticks at all until the bench issues exactly 32 pulses, so writes fall on a known side of the first tick. The same trick is used again after a stop/start to show that a new run reopens the window. A write that coincides with an underflow is reached by writing at a stride that drifts across the reload period.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
    localparam int MODE_W = 8;
    localparam logic [MODE_W-1:0] MODE_WMASK = 8'hCF;
    localparam int SEL_HI = 7;
    localparam int SEL_LO = 6;
    localparam logic [1:0] OP_TIMER = 2'b00;

    typedef enum logic [1:0] {
        SRC_FAST  = 2'b00,
        SRC_DIV8  = 2'b01,
        SRC_DIV32 = 2'b10,
        SRC_SLOW  = 2'b11
    } src_sel_e;
endpackage

// File: rtl/rdt_prescaler.sv
module rdt_prescaler #(
    parameter int DIV_A    = 2,
    parameter int DIV_B    = 8,
    parameter int DIV_C    = 32,
    parameter int SLOW_DIV = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_en_i,
    output logic [2:0] tap_o,
    output logic       slow_tick_o
);
    localparam int PW = $clog2(DIV_C);
    localparam int SW = $clog2(SLOW_DIV);
    localparam int DIVS [3] = '{DIV_A, DIV_B, DIV_C};

    typedef struct packed {
        logic [PW-1:0] pc;
        logic [SW-1:0] sc;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d    = pre_q;
        pre_d.pc = pre_q.pc + PW'(1);
        if (slow_en_i) begin
            pre_d.sc = pre_q.sc + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_tap
        localparam logic [PW-1:0] MASK = PW'(DIVS[g] - 1);
        assign tap_o[g] = ((pre_q.pc & MASK) == MASK);
    end

    assign slow_tick_o = slow_en_i && (pre_q.sc == {SW{1'b1}});
endmodule

// File: rtl/rdt_srcsel.sv
module rdt_srcsel
    import rdt_pkg::*;
(
    input  logic [1:0] sel_i,
    input  logic       half_rate_i,
    input  logic [2:0] tap_i,
    input  logic       slow_tick_i,
    output logic       tick_o
);
    always_comb begin
        unique case (src_sel_e'(sel_i))
            SRC_FAST:  tick_o = half_rate_i ? tap_i[0] : 1'b1;
            SRC_DIV8:  tick_o = tap_i[1];
            SRC_DIV32: tick_o = tap_i[2];
            SRC_SLOW:  tick_o = slow_tick_i;
            default:   tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rdt_core.sv
module rdt_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_tick_i,
    input  logic         start_i,
    input  logic         mode_ok_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] reload_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rel;
        logic         seen;
        logic         run;
        logic         irq;
    } core_t;

    core_t st_d, st_q;
    logic  tick;
    logic  live_seen;
    logic  load_both;

    always_comb begin
        tick      = src_tick_i && start_i && mode_ok_i;
        live_seen = st_q.seen && st_q.run;
        load_both = wr_i && !(start_i && live_seen);

        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_i) begin
            st_d.rel = wdata_i;
        end
        if (load_both) begin
            st_d.cnt = wdata_i;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = wr_i ? wdata_i : st_q.rel;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - W'(1);
            end
        end
        st_d.seen = start_i && (live_seen || tick);
        st_d.run  = start_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.cnt;
    assign reload_o = st_q.rel;
    assign irq_o    = st_q.irq;
endmodule

// File: rtl/rdt_timer.sv
module rdt_timer
    import rdt_pkg::*;
#(
    parameter int W        = 16,
    parameter int DIV_A    = 2,
    parameter int DIV_B    = 8,
    parameter int DIV_C    = 32,
    parameter int SLOW_DIV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_wr_i,
    input  logic [W-1:0]      tmr_wdata_i,
    input  logic              mode_wr_i,
    input  logic [MODE_W-1:0] mode_wdata_i,
    input  logic              start_i,
    input  logic              half_rate_i,
    input  logic              slow_en_i,
    output logic [W-1:0]      count_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              irq_o
);
    logic [MODE_W-1:0] mode_d, mode_q;
    logic [2:0]        tap;
    logic              slow_tick;
    logic              src_tick;
    logic [W-1:0]      reload_w;

    always_comb begin
        mode_d = mode_q;
        if (mode_wr_i) begin
            mode_d = mode_wdata_i & MODE_WMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    rdt_prescaler #(
        .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .SLOW_DIV(SLOW_DIV)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .slow_en_i(slow_en_i),
        .tap_o(tap), .slow_tick_o(slow_tick)
    );

    rdt_srcsel u_sel (
        .sel_i(mode_q[SEL_HI:SEL_LO]), .half_rate_i(half_rate_i),
        .tap_i(tap), .slow_tick_i(slow_tick), .tick_o(src_tick)
    );

    rdt_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick), .start_i(start_i),
        .mode_ok_i(mode_q[1:0] == OP_TIMER), .wr_i(tmr_wr_i),
        .wdata_i(tmr_wdata_i), .count_o(count_o), .reload_o(reload_w),
        .irq_o(irq_o)
    );

    assign mode_o = mode_q;
endmodule

// File: rtl/rdt_timer_chk.sv
module rdt_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         wr_en,
    input logic [W-1:0] count,
    input logic [W-1:0] reload,
    input logic [7:0]   mode,
    input logic         irq
);
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !wr_en) |=> $stable(count)); // R5

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && !irq && (count != $past(count)))
        |-> (count == W'($past(count) - 1'b1))); // R2

    AST_IRQ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(count) == '0)); // R3

    AST_IRQ_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == reload)); // R8

    AST_MODE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mode[5:4] == 2'b00); // R9

    AST_OTHER_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode[1:0] != 2'b00) && !wr_en) |=> $stable(count)); // R9
endmodule

bind rdt_timer rdt_timer_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start_i), .wr_en(tmr_wr_i),
    .count(count_o), .reload(reload_w), .mode(mode_o), .irq(irq_o)
);

// File: tb/rdt_timer_test.sv
module rdt_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_wr_i = 1'b0;
    logic [15:0] tmr_wdata_i = '0;
    logic        mode_wr_i = 1'b0;
    logic [7:0]  mode_wdata_i = '0;
    logic        start_i = 1'b0;
    logic        half_rate_i = 1'b0;
    logic        slow_en_i = 1'b0;
    logic [15:0] count_o;
    logic [7:0]  mode_o;
    logic        irq_o;

    rdt_timer uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [15:0] cnt;
        logic        irq;
        logic [7:0]  mode;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    string cur_tag = "R1";
    int    vectors = 0;
    int    misses = 0;
    bit    done = 1'b0;

    // reference model, built from the requirements
    int          m_clocks;
    int          m_pulses;
    logic [15:0] m_cnt, m_rel;
    logic [7:0]  m_mode;
    logic        m_fresh, m_prev_start;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clocks = 0; m_pulses = 0; m_cnt = 0; m_rel = 0; m_mode = 0;
            m_fresh = 1'b1; m_prev_start = 1'b0;
        end else begin
            bit   src, tick, both, irq;
            exp_t e;
            case (m_mode[7:6])
                2'b00:   src = half_rate_i ? (m_clocks % 2 == 1) : 1'b1;
                2'b01:   src = (m_clocks % 8 == 7);
                2'b10:   src = (m_clocks % 32 == 31);
                default: src = slow_en_i && (m_pulses % 32 == 31);
            endcase
            tick = src && start_i && (m_mode[1:0] == 2'b00);
            if (!m_prev_start) m_fresh = 1'b1;
            both = tmr_wr_i && (!start_i || m_fresh);
            irq = 1'b0;
            if (both) begin
                m_cnt = tmr_wdata_i;
            end else if (tick) begin
                if (m_cnt == 0) begin
                    m_cnt = tmr_wr_i ? tmr_wdata_i : m_rel;
                    irq = 1'b1;
                end else begin
                    m_cnt = m_cnt - 16'd1;
                end
            end
            if (tmr_wr_i) m_rel = tmr_wdata_i;
            if (start_i && tick) m_fresh = 1'b0;
            m_prev_start = start_i;
            if (mode_wr_i) m_mode = {mode_wdata_i[7:6], 2'b00, mode_wdata_i[3:0]};
            m_clocks++;
            if (slow_en_i) m_pulses++;
            e.cnt = m_cnt; e.irq = irq; e.mode = m_mode;
            exp_q.push_back(e);
            tag_q.push_back(cur_tag);
        end
    end

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (count_o !== e.cnt || irq_o !== e.irq || mode_o !== e.mode) begin
                misses++;
                $display("FAIL %s: count=%h irq=%b mode=%h expected count=%h irq=%b mode=%h",
                         t, count_o, irq_o, mode_o, e.cnt, e.irq, e.mode);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_timer(input logic [15:0] v);
        tmr_wr_i = 1'b1; tmr_wdata_i = v;
        @(negedge clk);
        tmr_wr_i = 1'b0;
    endtask

    task automatic wr_mode(input logic [7:0] v);
        mode_wr_i = 1'b1; mode_wdata_i = v;
        @(negedge clk);
        mode_wr_i = 1'b0;
    endtask

    task automatic pulses(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            slow_en_i = 1'b1;
            @(negedge clk);
            slow_en_i = 1'b0;
            cyc(gap);
        end
    endtask

    task automatic chk_reset();
        vectors++;
        if (count_o !== 16'h0 || mode_o !== 8'h00 || irq_o !== 1'b0) begin
            misses++;
            $display("FAIL R1: count=%h mode=%h irq=%b expected 0000 00 0",
                     count_o, mode_o, irq_o);
        end
    endtask

    initial begin
        cyc(3);
        chk_reset(); // R1
        rst_n = 1'b1;
        chk_reset(); // R1
        cyc(2);

        cur_tag = "R6";  // write while stopped
        wr_timer(16'd5);
        cyc(3);
        cur_tag = "R2";  // fast source, decrement and underflow R3
        start_i = 1'b1;
        cyc(20);
        cur_tag = "R7";  // mid-run write reaches reload only
        wr_timer(16'd9);
        cyc(25);
        cur_tag = "R8";  // writes drift across underflow
        for (int k = 0; k < 12; k++) begin
            wr_timer(16'd4);
            cyc(5);
        end
        cur_tag = "R5";  // stopped holds
        start_i = 1'b0;
        cyc(12);
        wr_timer(16'd3);
        cyc(4);

        cur_tag = "R6";  // slow source, no pulses: before first tick
        wr_mode(8'hC0);
        start_i = 1'b1;
        cyc(3);
        wr_timer(16'd2);
        cyc(3);
        wr_timer(16'd7);
        cyc(2);
        cur_tag = "R7";
        pulses(32, 1);
        wr_timer(16'd1);
        cyc(2);
        pulses(40, 0);
        cur_tag = "R10"; // restart reopens the window
        start_i = 1'b0;
        cyc(1);
        start_i = 1'b1;
        cyc(2);
        wr_timer(16'd6);
        cyc(3);

        cur_tag = "R4";  // each source in turn
        pulses(100, 2);
        wr_mode(8'h00);
        half_rate_i = 1'b1;
        wr_timer(16'd3);
        cyc(40);
        half_rate_i = 1'b0;
        wr_mode(8'h40);
        cyc(120);
        wr_mode(8'h80);
        cyc(400);

        cur_tag = "R9";  // non-timer mode freezes; reserved bits
        wr_mode(8'hFF);
        cyc(80);
        wr_mode(8'h01);
        cyc(40);
        wr_mode(8'h0C);
        cyc(30);

        cur_tag = "R3";  // boundaries n=0 and n=FFFF
        wr_mode(8'h00);
        start_i = 1'b0;
        cyc(1);
        wr_timer(16'h0000);
        start_i = 1'b1;
        cyc(10);
        start_i = 1'b0;
        cyc(1);
        wr_timer(16'hFFFF);
        start_i = 1'b1;
        cyc(65540);
        start_i = 1'b0;
        cyc(4);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            misses++;
            vectors++;
            $display("FAIL watchdog: actual=hung expected=finished");
        end
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule